// File: doc/BRIEF.md
# Consecutive-Cycle PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches two single-cycle edge pulses, one from the reference comparison clock and one from the divided feedback clock. Both are already in the domain of a fast sampling clock. For every reference edge it measures the phase error as the number of sampling ticks to the nearest feedback edge, looking either side of the reference edge. It then judges that comparison cycle to be inside or outside a tolerance window. Lock is declared once enough judged cycles in a row fall inside the window.

Two control bits shape the decision. The mode bit selects integer detection (1), meant for loops whose fractional part is zero, or fractional detection (0). The precision bit then picks the window. The pairing is asymmetric:

| Mode | Precision bit | Window | Cycles in a row |
|------|---------------|--------|-----------------|
| fractional | 0 | wide | 40 |
| fractional | 1 | narrow | 40 |
| integer | 0 | narrow | 5 |
| integer | 1 | wide | 5 |

The widths are parameters counted in sampling ticks, with defaults of 10 and 6. A power-down input, or any change to either control bit, throws away the history collected so far.

Top module: `pll_lock_watch`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `locked` is 0.
- R2: With `int_mode`=0 and `fine_sel`=0, the window is WIDE_TICKS (default 10). `locked` becomes 1 at the end of the 40th consecutive in-window comparison cycle and not before.
- R3: With `int_mode`=0 and `fine_sel`=1, the window is NARROW_TICKS (default 6) and the run length is 40. An error of 7 ticks never leads to lock.
- R4: With `int_mode`=1 and `fine_sel`=0, the window is NARROW_TICKS and the run length is 5. An error of 7 ticks never leads to lock.
- R5: With `int_mode`=1 and `fine_sel`=1, the window is WIDE_TICKS and the run length is 5.
- R6: The phase error is the tick distance from a reference pulse to the nearest feedback pulse, whether that pulse comes earlier or later. A pulse in the same cycle gives an error of 0. A cycle is in-window when the error is less than or equal to the window.
- R7: A reference pulse with no feedback pulse within the window on either side is an out-of-window cycle.
- R8: An out-of-window cycle drops `locked` on the next clock edge and restarts the count from zero.
- R9: Any change of `int_mode` or `fine_sel` drops `locked` and restarts the count.
- R10: While `pwr_down` is 1, the count is held at zero and `locked` stays 0, whatever pulses arrive.
- R11: Once locked, `locked` stays 1 for as long as cycles keep arriving in-window. The count holds at the run length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down: clears the detector while high |
| int_mode | input | 1 | 1 = integer detection, 0 = fractional detection |
| fine_sel | input | 1 | Precision bit that selects the window together with `int_mode` |
| ref_pulse | input | 1 | One-cycle pulse per reference comparison edge |
| fb_pulse | input | 1 | One-cycle pulse per feedback edge |
| locked | output | 1 | Registered lock indication |

## Verification
The assertions take for granted that reference pulses are spaced more than twice the wide window apart. With that spacing, one comparison never overlaps the next, and a feedback pulse is never claimed by two reference edges. The stimulus uses a 41-tick comparison period with the reference pulse at a fixed slot. Each feedback pulse sits at most 12 ticks from that slot, so every judgement ends well inside its own period. Control bits change only between periods, and the lock output is sampled at period boundaries, where it has settled.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic {
    MEAS_IDLE = 1'b0,
    MEAS_WAIT = 1'b1
  } meas_state_t;
endpackage

// File: rtl/lockdet_mode_table.sv
module lockdet_mode_table #(
  parameter int WIDE_TICKS   = 10,
  parameter int NARROW_TICKS = 6,
  parameter int FRAC_RUN     = 40,
  parameter int INT_RUN      = 5,
  parameter int TW           = 4,
  parameter int RW           = 6
) (
  input  logic          int_mode,
  input  logic          fine_sel,
  output logic [TW-1:0] thr,
  output logic [RW-1:0] run_len
);
  // Asymmetric pairing: the precision bit widens the window in integer mode
  // and narrows it in fractional mode.
  always_comb begin
    if (int_mode) begin
      run_len = RW'(INT_RUN);
      thr     = fine_sel ? TW'(WIDE_TICKS) : TW'(NARROW_TICKS);
    end else begin
      run_len = RW'(FRAC_RUN);
      thr     = fine_sel ? TW'(NARROW_TICKS) : TW'(WIDE_TICKS);
    end
  end
endmodule

// File: rtl/lockdet_phase_meter.sv
module lockdet_phase_meter
  import lockdet_pkg::*;
#(
  parameter int SAT = 11,
  parameter int TW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ref_pulse,
  input  logic          fb_pulse,
  input  logic [TW-1:0] thr,
  output logic          verdict_vld,
  output logic          verdict_ok
);
  meas_state_t   state;
  logic [TW-1:0] fb_age;
  logic [TW-1:0] wait_cnt;
  logic [TW-1:0] back_dist;
  logic [TW-1:0] fwd_dist;

  // Ticks since the most recent feedback pulse, saturating.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fb_age <= TW'(SAT);
    end else if (fb_pulse) begin
      fb_age <= '0;
    end else if (fb_age != TW'(SAT)) begin
      fb_age <= fb_age + TW'(1);
    end
  end

  always_comb begin
    if (fb_pulse) begin
      back_dist = '0;
    end else if (fb_age == TW'(SAT)) begin
      back_dist = TW'(SAT);
    end else begin
      back_dist = fb_age + TW'(1);
    end
    fwd_dist = wait_cnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state       <= MEAS_IDLE;
      wait_cnt    <= '0;
      verdict_vld <= 1'b0;
      verdict_ok  <= 1'b0;
    end else begin
      verdict_vld <= 1'b0;
      verdict_ok  <= 1'b0;
      case (state)
        MEAS_IDLE: begin
          if (ref_pulse) begin
            if (back_dist <= thr) begin
              verdict_vld <= 1'b1;
              verdict_ok  <= 1'b1;
            end else begin
              state    <= MEAS_WAIT;
              wait_cnt <= '0;
            end
          end
        end
        MEAS_WAIT: begin
          if (fb_pulse && (fwd_dist <= thr)) begin
            verdict_vld <= 1'b1;
            verdict_ok  <= 1'b1;
            state       <= MEAS_IDLE;
          end else if (ref_pulse || (fwd_dist >= thr)) begin
            verdict_vld <= 1'b1;
            verdict_ok  <= 1'b0;
            state       <= ref_pulse ? MEAS_WAIT : MEAS_IDLE;
            wait_cnt    <= '0;
          end else begin
            wait_cnt <= fwd_dist;
          end
        end
        default: state <= MEAS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lockdet_run_counter.sv
module lockdet_run_counter #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          verdict_vld,
  input  logic          verdict_ok,
  input  logic [RW-1:0] run_len,
  output logic [RW-1:0] run_cnt,
  output logic          locked
);
  logic [RW:0] next_cnt;

  assign next_cnt = {1'b0, run_cnt} + (RW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (verdict_vld) begin
      if (verdict_ok) begin
        if (run_cnt != run_len) begin
          run_cnt <= next_cnt[RW-1:0];
        end
        locked <= (next_cnt >= {1'b0, run_len});
      end else begin
        run_cnt <= '0;
        locked  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch #(
  parameter int WIDE_TICKS   = 10,
  parameter int NARROW_TICKS = 6,
  parameter int FRAC_RUN     = 40,
  parameter int INT_RUN      = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down,
  input  logic int_mode,
  input  logic fine_sel,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic locked
);
  localparam int MAX_WIN = (WIDE_TICKS > NARROW_TICKS) ? WIDE_TICKS : NARROW_TICKS;
  localparam int SAT     = MAX_WIN + 1;
  localparam int TW      = $clog2(SAT + 1);
  localparam int MAX_RUN = (FRAC_RUN > INT_RUN) ? FRAC_RUN : INT_RUN;
  localparam int RW      = $clog2(MAX_RUN + 1);

  logic [1:0]    cfg_q;
  logic          cfg_change;
  logic          clr;
  logic [TW-1:0] thr;
  logic [RW-1:0] run_len;
  logic [RW-1:0] run_cnt;
  logic          verdict_vld;
  logic          verdict_ok;

  always_ff @(posedge clk) begin
    cfg_q <= {int_mode, fine_sel};
  end

  assign cfg_change = !rst && (cfg_q != {int_mode, fine_sel});
  assign clr        = pwr_down || cfg_change;

  lockdet_mode_table #(
    .WIDE_TICKS  (WIDE_TICKS),
    .NARROW_TICKS(NARROW_TICKS),
    .FRAC_RUN    (FRAC_RUN),
    .INT_RUN     (INT_RUN),
    .TW          (TW),
    .RW          (RW)
  ) u_table (
    .int_mode(int_mode),
    .fine_sel(fine_sel),
    .thr     (thr),
    .run_len (run_len)
  );

  lockdet_phase_meter #(
    .SAT(SAT),
    .TW (TW)
  ) u_meter (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .ref_pulse  (ref_pulse),
    .fb_pulse   (fb_pulse),
    .thr        (thr),
    .verdict_vld(verdict_vld),
    .verdict_ok (verdict_ok)
  );

  lockdet_run_counter #(
    .RW(RW)
  ) u_run (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .verdict_vld(verdict_vld),
    .verdict_ok (verdict_ok),
    .run_len    (run_len),
    .run_cnt    (run_cnt),
    .locked     (locked)
  );
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_down,
  input logic          int_mode,
  input logic          fine_sel,
  input logic          verdict_vld,
  input logic          verdict_ok,
  input logic [RW-1:0] run_cnt,
  input logic [RW-1:0] run_len,
  input logic          locked
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !locked);

  assert_rise_after_ok_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(verdict_vld && verdict_ok));

  assert_fail_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (verdict_vld && !verdict_ok && !pwr_down) |=> !locked && (run_cnt == '0));

  assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable({int_mode, fine_sel}) |=> !locked && (run_cnt == '0));

  assert_pwr_clear_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> !locked && (run_cnt == '0));

  assert_lock_full_run_R11: assert property (@(posedge clk) disable iff (rst)
    (locked && $stable({int_mode, fine_sel})) |-> (run_cnt == run_len));
endmodule

bind pll_lock_watch lockdet_checker #(.RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_down   (pwr_down),
  .int_mode   (int_mode),
  .fine_sel   (fine_sel),
  .verdict_vld(verdict_vld),
  .verdict_ok (verdict_ok),
  .run_cnt    (run_cnt),
  .run_len    (run_len),
  .locked     (locked)
);

// File: tb/sim_pll_lock_watch.sv
module sim_pll_lock_watch;
  localparam int CLK_PERIOD = 10;
  localparam int PER        = 40;
  localparam int REF_AT     = 15;
  localparam int WIDE       = 10;
  localparam int NARROW     = 6;
  localparam int FRUN       = 40;
  localparam int IRUN       = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_down = 1'b0;
  logic int_mode = 1'b0;
  logic fine_sel = 1'b0;
  logic ref_pulse = 1'b0;
  logic fb_pulse = 1'b0;
  logic locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_watch #(
    .WIDE_TICKS  (WIDE),
    .NARROW_TICKS(NARROW),
    .FRAC_RUN    (FRUN),
    .INT_RUN     (IRUN)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .int_mode (int_mode),
    .fine_sel (fine_sel),
    .ref_pulse(ref_pulse),
    .fb_pulse (fb_pulse),
    .locked   (locked)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: locked=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One comparison period; off is the feedback offset from the reference slot.
  task automatic one_period(input int off, input bit miss);
    for (int t = 0; t < PER; t++) begin
      @(negedge clk);
      ref_pulse = (t == REF_AT);
      fb_pulse  = !miss && (t == REF_AT + off);
    end
    @(negedge clk);
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
  endtask

  task automatic restart(input bit im, input bit fs);
    @(negedge clk);
    int_mode = im;
    fine_sel = fs;
    pwr_down = 1'b1;
    repeat (2) @(negedge clk);
    pwr_down = 1'b0;
  endtask

  task automatic lock_run(input bit im, input bit fs, input int need,
                          input int off, input string req);
    restart(im, fs);
    for (int k = 1; k <= need; k++) begin
      one_period(off, 1'b0);
      if (k == need - 1) check(req, locked, 0);
      if (k == need)     check(req, locked, 1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", locked, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", locked, 0);
  endtask

  // R2 and R6: wide window in fractional mode, fb late and early at the edge.
  task automatic t_frac_coarse();
    lock_run(1'b0, 1'b0, FRUN, WIDE, "R2");
    lock_run(1'b0, 1'b0, FRUN, -WIDE, "R6");
    restart(1'b0, 1'b0);
    for (int k = 0; k < FRUN - 1; k++) one_period(WIDE - 3, 1'b0);
    one_period(WIDE + 1, 1'b0);
    check("R8", locked, 0);
    one_period(0, 1'b0);
    check("R8", locked, 0);
  endtask

  // R3: narrow window in fractional mode.
  task automatic t_frac_fine();
    lock_run(1'b0, 1'b1, FRUN, -NARROW, "R3");
    restart(1'b0, 1'b1);
    for (int k = 0; k < FRUN + 5; k++) one_period(NARROW + 1, 1'b0);
    check("R3", locked, 0);
  endtask

  // R4: narrow window in integer mode.
  task automatic t_int_coarse();
    lock_run(1'b1, 1'b0, IRUN, NARROW, "R4");
    restart(1'b1, 1'b0);
    for (int k = 0; k < 2 * IRUN; k++) one_period(-(NARROW + 1), 1'b0);
    check("R4", locked, 0);
  endtask

  // R5: wide window in integer mode, then one early violation.
  task automatic t_int_fine();
    lock_run(1'b1, 1'b1, IRUN, WIDE, "R5");
    one_period(-(WIDE + 1), 1'b0);
    check("R8", locked, 0);
  endtask

  // R7: a missing feedback pulse breaks the run.
  task automatic t_missing();
    lock_run(1'b1, 1'b1, IRUN, 0, "R7");
    one_period(0, 1'b1);
    check("R7", locked, 0);
    for (int k = 1; k <= IRUN; k++) begin
      one_period(2, 1'b0);
      if (k == IRUN - 1) check("R7", locked, 0);
      if (k == IRUN)     check("R7", locked, 1);
    end
  endtask

  // R11: lock is held while good cycles continue.
  task automatic t_hold();
    lock_run(1'b1, 1'b1, IRUN, 3, "R11");
    for (int k = 0; k < 20; k++) one_period((k % 2 == 0) ? 3 : -3, 1'b0);
    check("R11", locked, 1);
  endtask

  // R9: a change of the precision bit restarts the count.
  task automatic t_cfg();
    lock_run(1'b1, 1'b1, IRUN, 3, "R9");
    @(negedge clk);
    fine_sel = 1'b0;
    @(negedge clk);
    check("R9", locked, 0);
    for (int k = 1; k <= IRUN; k++) begin
      one_period(3, 1'b0);
      if (k == IRUN - 1) check("R9", locked, 0);
      if (k == IRUN)     check("R9", locked, 1);
    end
  endtask

  // R10: power-down clears lock and ignores pulses while high.
  task automatic t_pwr();
    lock_run(1'b1, 1'b1, IRUN, 1, "R10");
    @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    check("R10", locked, 0);
    for (int k = 0; k < IRUN + 1; k++) one_period(1, 1'b0);
    check("R10", locked, 0);
    pwr_down = 1'b0;
    for (int k = 1; k <= IRUN; k++) begin
      one_period(1, 1'b0);
      if (k == IRUN - 1) check("R10", locked, 0);
      if (k == IRUN)     check("R10", locked, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_frac_coarse();
    t_frac_fine();
    t_int_coarse();
    t_int_fine();
    t_missing();
    t_hold();
    t_cfg();
    t_pwr();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule